// File: doc/BRIEF.md
# Sixteen-bit Multicycle Instruction Execution Core

This block runs programs for a 16-bit word-addressed load/store machine with eight general registers, a program counter and three condition flags. Each instruction is fetched through one memory port, the counter is bumped as the fetch is accepted, and the instruction then takes the few cycles it needs. Those cycles cover register arithmetic and logic, direct, base-plus-offset and two-level loads and stores, conditional branches, jumps and subroutine calls.

The memory port is a request stream with valid/ready. The core raises `mem_req_valid` and keeps the address, the write flag and the write data steady until the cycle in which `mem_req_ready` is high. A request is accepted on any clock edge where both are high. Only reads are answered. The answer is a single-cycle `mem_rsp_valid` pulse carrying the data, it can arrive one or more cycles after acceptance, and the core has no way to stall it. Only one request is outstanding at any time.

Three opcodes are not executed in the core: return-from-interrupt (8), the reserved code (13) and trap (15). For these the core raises `exc_req` and shows the instruction word and the incremented counter. It waits with no memory traffic. When the external sequencer pulses `exc_ack`, the core resumes fetching at `exc_target`.

Top module: `core16_exec`

## Requirements
- R1: After reset the counter is 16'h3000, all eight registers read zero, `cond_flags` is 3'b010, `exc_req` is low, and the first request is a read of 16'h3000.
- R2: Every request keeps its address, write flag and write data steady while `mem_req_ready` is low. A fetch is accepted at the counter value, the counter then increases by one, and the next request waits for the read answer.
- R3: Opcode is bits [15:12], destination/source register is [11:9], base/first operand is [8:6]. Add (1) and and (5) take their second operand from bits [4:0] sign-extended when bit 5 is 1, and from the register named by [2:0] when bit 5 is 0. Not (9) inverts the base register.
- R4: After add, and, not, load (2), register-offset load (6), indirect load (10) and effective address (14), exactly one flag is set for the value written: bit 2 for negative, bit 1 for zero, bit 0 for positive.
- R5: Stores, branches, jumps and calls leave `cond_flags` unchanged.
- R6: Load (2), store (3) and effective address (14) use counter + 1 plus the 9-bit signed offset in [8:0]. Effective address writes that sum to the register and makes no memory access.
- R7: Register-offset load (6) and store (7) use the base register plus the 6-bit signed offset in [5:0]. Store data comes from the register in [11:9].
- R8: Indirect load (10) and store (11) first read a pointer at counter + 1 plus the 9-bit offset, then read or write the data word at that pointer.
- R9: Branch (0) moves the counter by the 9-bit offset only when bits [11:9] ANDed with `cond_flags` is nonzero.
- R10: Jump (12) loads the counter from the base register. Call (4) writes the incremented counter to R7 and targets either counter + 1 plus the 11-bit offset (bit 11 = 1) or the base register (bit 11 = 0, read before R7 is written).
- R11: Opcodes 8, 13 and 15 raise `exc_req` with the instruction word and the incremented counter. `exc_req` stays high with no memory request until `exc_ack`, and fetching then resumes at `exc_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | 16 | Word address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 16 | Read data |
| exc_req | output | 1 | Exception hand-off request |
| exc_ack | input | 1 | Sequencer done, take `exc_target` |
| exc_instr | output | 16 | Instruction word that raised the hand-off |
| exc_pc | output | 16 | Incremented counter at hand-off |
| exc_target | input | 16 | Counter value to resume at |
| cond_flags | output | 3 | Negative, zero, positive flags |

## Verification
The hardest case to reach is back-pressure in the middle of a two-level access. Here the pointer has already come back and the second request, a read or a write at that pointer, has to stay steady while ready is low. A hand-off that overlaps a stalled memory cycle is similar. The bench drives ready low in a fixed pattern spread across the cycles and changes the response latency between one and two cycles. Over the instruction sequence this lands stalls on fetches, pointer reads, data reads and writes. Every accepted request is compared with a behavioural instruction model. A fixed program makes the loop, branch and call paths fire in a known order, and each hand-off resumes one word past the raising instruction so the skipped word proves that `exc_target` was used.

// File: rtl/core16_pkg.sv
package core16_pkg;

  parameter int unsigned WORD_W = 16;
  parameter int unsigned FLG_W  = 3;

  localparam logic [FLG_W-1:0] FLG_POS = 3'b001;
  localparam logic [FLG_W-1:0] FLG_ZER = 3'b010;
  localparam logic [FLG_W-1:0] FLG_NEG = 3'b100;

  typedef enum logic [3:0] {
    OPC_BRANCH = 4'd0,  OPC_ADD    = 4'd1,  OPC_LOAD   = 4'd2,  OPC_STORE  = 4'd3,
    OPC_CALL   = 4'd4,  OPC_AND    = 4'd5,  OPC_LOADR  = 4'd6,  OPC_STORER = 4'd7,
    OPC_RETI   = 4'd8,  OPC_NOT    = 4'd9,  OPC_LOADI  = 4'd10, OPC_STOREI = 4'd11,
    OPC_JUMP   = 4'd12, OPC_RSVD   = 4'd13, OPC_ADDR   = 4'd14, OPC_TRAP   = 4'd15
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FETCH, ST_IWAIT, ST_EXEC, ST_PTR_REQ, ST_PTR_WAIT,
    ST_RD_REQ, ST_RD_WAIT, ST_WR_REQ, ST_EXC
  } state_e;

  // sign-extend the low 'bits' bits of v to a full word
  function automatic logic [WORD_W-1:0] sext(input logic [WORD_W-1:0] v, input int bits);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < int'(WORD_W); i++)
      r[i] = (i < bits) ? v[i] : v[bits-1];
    return r;
  endfunction

  function automatic logic [FLG_W-1:0] flags_of(input logic [WORD_W-1:0] v);
    if (v == '0)          return FLG_ZER;
    else if (v[WORD_W-1]) return FLG_NEG;
    else                  return FLG_POS;
  endfunction

endpackage

// File: rtl/core16_regfile.sv
module core16_regfile #(
  parameter int unsigned NREG = 8,
  parameter int unsigned W    = 16,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_sel,
  input  logic [AW-1:0] rd_b_sel,
  input  logic [AW-1:0] rd_c_sel,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREG); i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[wr_sel] <= wr_data;
    end
  end

  assign rd_a = regs[rd_a_sel];
  assign rd_b = regs[rd_b_sel];
  assign rd_c = regs[rd_c_sel];
endmodule

// File: rtl/core16_calc.sv
module core16_calc
  import core16_pkg::*;
(
  input  logic [WORD_W-1:0] ir,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] alu_res,
  output logic [WORD_W-1:0] pc_rel9,
  output logic [WORD_W-1:0] pc_rel11,
  output logic [WORD_W-1:0] base_off6
);
  localparam int OFF_SHORT = 6;
  localparam int OFF_MID   = 9;
  localparam int OFF_LONG  = 11;
  localparam int IMM_W     = 5;

  opcode_e           opc;
  logic [WORD_W-1:0] second;

  assign opc       = opcode_e'(ir[15:12]);
  assign second    = ir[5] ? sext(ir, IMM_W) : op_b;
  assign pc_rel9   = pc + sext(ir, OFF_MID);
  assign pc_rel11  = pc + sext(ir, OFF_LONG);
  assign base_off6 = op_a + sext(ir, OFF_SHORT);

  always_comb begin
    unique case (opc)
      OPC_ADD:  alu_res = op_a + second;
      OPC_AND:  alu_res = op_a & second;
      OPC_NOT:  alu_res = ~op_a;
      OPC_ADDR: alu_res = pc_rel9;
      default:  alu_res = '0;
    endcase
  end
endmodule

// File: rtl/core16_seq.sv
module core16_seq
  import core16_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC = 16'h3000,
  parameter int unsigned       RA_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [WORD_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              exc_req,
  input  logic              exc_ack,
  output logic [WORD_W-1:0] exc_instr,
  output logic [WORD_W-1:0] exc_pc,
  input  logic [WORD_W-1:0] exc_target,
  output logic [FLG_W-1:0]  cond_flags,
  output logic [WORD_W-1:0] ir_q,
  output logic [WORD_W-1:0] pc_q,
  input  logic [WORD_W-1:0] rf_a,
  input  logic [WORD_W-1:0] rf_c,
  input  logic [WORD_W-1:0] alu_res,
  input  logic [WORD_W-1:0] pc_rel9,
  input  logic [WORD_W-1:0] pc_rel11,
  input  logic [WORD_W-1:0] base_off6,
  output logic              rf_we,
  output logic [RA_W-1:0]   rf_wa,
  output logic [WORD_W-1:0] rf_wd
);
  localparam logic [RA_W-1:0] LINK_REG = RA_W'(7);

  state_e            state;
  opcode_e           opc;
  logic [WORD_W-1:0] maddr;
  logic [FLG_W-1:0]  flags;
  logic              alu_write, keeps_flags;

  assign opc = opcode_e'(ir_q[15:12]);
  assign alu_write = (opc == OPC_ADD) || (opc == OPC_AND) ||
                     (opc == OPC_NOT) || (opc == OPC_ADDR);
  assign keeps_flags = (opc == OPC_BRANCH) || (opc == OPC_STORE) || (opc == OPC_STORER) ||
                       (opc == OPC_STOREI) || (opc == OPC_JUMP) || (opc == OPC_CALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      maddr <= '0;
      flags <= FLG_ZER;
    end else begin
      unique case (state)
        ST_FETCH: if (mem_req_ready) begin
          pc_q  <= pc_q + 1'b1;
          state <= ST_IWAIT;
        end
        ST_IWAIT: if (mem_rsp_valid) begin
          ir_q  <= mem_rsp_data;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_FETCH;
          unique case (opc)
            OPC_BRANCH: if ((ir_q[11:9] & flags) != '0) pc_q <= pc_rel9;
            OPC_ADD, OPC_AND, OPC_NOT, OPC_ADDR: flags <= flags_of(alu_res);
            OPC_LOAD:   begin maddr <= pc_rel9;   state <= ST_RD_REQ;  end
            OPC_LOADR:  begin maddr <= base_off6; state <= ST_RD_REQ;  end
            OPC_STORE:  begin maddr <= pc_rel9;   state <= ST_WR_REQ;  end
            OPC_STORER: begin maddr <= base_off6; state <= ST_WR_REQ;  end
            OPC_LOADI, OPC_STOREI: begin maddr <= pc_rel9; state <= ST_PTR_REQ; end
            OPC_JUMP:   pc_q <= rf_a;
            OPC_CALL:   pc_q <= ir_q[11] ? pc_rel11 : rf_a;
            default:    state <= ST_EXC;
          endcase
        end
        ST_PTR_REQ:  if (mem_req_ready) state <= ST_PTR_WAIT;
        ST_PTR_WAIT: if (mem_rsp_valid) begin
          maddr <= mem_rsp_data;
          state <= (opc == OPC_LOADI) ? ST_RD_REQ : ST_WR_REQ;
        end
        ST_RD_REQ:  if (mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          flags <= flags_of(mem_rsp_data);
          state <= ST_FETCH;
        end
        ST_WR_REQ: if (mem_req_ready) state <= ST_FETCH;
        ST_EXC: if (exc_ack) begin
          pc_q  <= exc_target;
          state <= ST_FETCH;
        end
        default: state <= ST_FETCH;
      endcase
    end
  end

  // register write port: ALU results and links in EXEC, load data on answer
  always_comb begin
    rf_we = 1'b0;
    rf_wa = ir_q[11:9];
    rf_wd = alu_res;
    if (state == ST_EXEC && alu_write) begin
      rf_we = 1'b1;
    end else if (state == ST_EXEC && opc == OPC_CALL) begin
      rf_we = 1'b1;
      rf_wa = LINK_REG;
      rf_wd = pc_q;
    end else if (state == ST_RD_WAIT && mem_rsp_valid) begin
      rf_we = 1'b1;
      rf_wd = mem_rsp_data;
    end
  end

  assign mem_req_valid = (state == ST_FETCH) || (state == ST_PTR_REQ) ||
                         (state == ST_RD_REQ) || (state == ST_WR_REQ);
  assign mem_req_write = (state == ST_WR_REQ);
  assign mem_req_addr  = (state == ST_FETCH) ? pc_q : maddr;
  assign mem_req_wdata = rf_c;
  assign exc_req       = (state == ST_EXC);
  assign exc_instr     = ir_q;
  assign exc_pc        = pc_q;
  assign cond_flags    = flags;

  AST_REQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_write) && (!mem_req_write || $stable(mem_req_wdata)))); // R2
  AST_FETCH_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && mem_req_ready) |=> (pc_q == $past(mem_req_addr) + 1'b1)); // R2
  AST_FLAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cond_flags) == 1); // R4
  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && keeps_flags) |=> $stable(cond_flags)); // R5
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exc_ack) |=> exc_req); // R11
  AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !mem_req_valid); // R11
endmodule

// File: rtl/core16_exec.sv
module core16_exec
  import core16_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h3000,
  parameter int unsigned NREG     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [15:0] mem_req_addr,
  output logic [15:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [15:0] mem_rsp_data,
  output logic        exc_req,
  input  logic        exc_ack,
  output logic [15:0] exc_instr,
  output logic [15:0] exc_pc,
  input  logic [15:0] exc_target,
  output logic [2:0]  cond_flags
);
  localparam int unsigned RA_W = $clog2(NREG);

  logic [WORD_W-1:0] ir, pc, rf_a, rf_b, rf_c;
  logic [WORD_W-1:0] alu_res, pc_rel9, pc_rel11, base_off6, rf_wd;
  logic              rf_we;
  logic [RA_W-1:0]   rf_wa;

  core16_regfile #(.NREG(NREG), .W(WORD_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(ir[8:6]), .rd_b_sel(ir[2:0]), .rd_c_sel(ir[11:9]),
    .rd_a(rf_a), .rd_b(rf_b), .rd_c(rf_c),
    .wr_en(rf_we), .wr_sel(rf_wa), .wr_data(rf_wd)
  );

  core16_calc u_calc (
    .ir(ir), .pc(pc), .op_a(rf_a), .op_b(rf_b),
    .alu_res(alu_res), .pc_rel9(pc_rel9), .pc_rel11(pc_rel11), .base_off6(base_off6)
  );

  core16_seq #(.RESET_PC(RESET_PC), .RA_W(RA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .exc_req(exc_req), .exc_ack(exc_ack),
    .exc_instr(exc_instr), .exc_pc(exc_pc), .exc_target(exc_target),
    .cond_flags(cond_flags), .ir_q(ir), .pc_q(pc),
    .rf_a(rf_a), .rf_c(rf_c), .alu_res(alu_res), .pc_rel9(pc_rel9),
    .pc_rel11(pc_rel11), .base_off6(base_off6),
    .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd)
  );
endmodule

// File: tb/tb_core16_exec.sv
`timescale 1ns/1ps
module tb_core16_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req_valid, mem_req_write, mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        exc_req, exc_ack = 1'b0;
  logic [15:0] exc_instr, exc_pc, exc_target = '0;
  logic [2:0]  cond_flags;

  always #2 clk = ~clk;

  core16_exec dut (
    .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .exc_req(exc_req),
    .exc_ack(exc_ack), .exc_instr(exc_instr), .exc_pc(exc_pc), .exc_target(exc_target),
    .cond_flags(cond_flags)
  );

  localparam int KIND_RD = 0, KIND_WR = 1, KIND_EXC = 2;
  typedef struct packed { logic [1:0] kind; logic [15:0] addr; logic [15:0] data; logic [2:0] flg; } ev_t;
  ev_t   evq[$];
  string tagq[$];
  string ftagq[$];

  bit [15:0] bmem [int];   // memory the bench serves
  bit [15:0] mm   [int];   // model memory
  bit [15:0] mr   [8];
  bit [15:0] mpc;
  bit [2:0]  mflg;
  int nvec = 0, nbad = 0;
  int ptr;
  localparam int D = 'h3080, S = 'h3070;
  int end_pc;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------------- encoders ----------------
  function automatic bit [15:0] e_alu_i(int op, int d, int a, int imm);
    return {4'(op), 3'(d), 3'(a), 1'b1, 5'(imm)}; endfunction
  function automatic bit [15:0] e_alu_r(int op, int d, int a, int b);
    return {4'(op), 3'(d), 3'(a), 3'b000, 3'(b)}; endfunction
  function automatic bit [15:0] e_rel9(int op, int r, int here, int tgt);
    return {4'(op), 3'(r), 9'(tgt - (here + 1))}; endfunction
  function automatic bit [15:0] e_base(int op, int r, int b, int off);
    return {4'(op), 3'(r), 3'(b), 6'(off)}; endfunction

  task automatic put(input int a, input bit [15:0] w);
    bmem[a] = w; mm[a] = w;
  endtask
  task automatic emit(input bit [15:0] w);
    put(ptr, w); ptr++;
  endtask

  function automatic bit [15:0] sx(bit [15:0] v, int bits);
    int x;
    x = int'(v) & ((1 << bits) - 1);
    if (x >= (1 << (bits - 1))) x -= (1 << bits);
    return 16'(x);
  endfunction

  function automatic string tag_of(bit [3:0] op);
    case (op)
      4'd0:  return "R9";
      4'd1, 4'd5, 4'd9: return "R3";
      4'd2, 4'd3, 4'd14: return "R6";
      4'd6, 4'd7: return "R7";
      4'd10, 4'd11: return "R8";
      4'd4, 4'd12: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic push(input int kind, input bit [15:0] a, input bit [15:0] d, input bit [2:0] f,
                      input string t, input string ft);
    ev_t e;
    e.kind = 2'(kind); e.addr = a; e.data = d; e.flg = f;
    evq.push_back(e); tagq.push_back(t); ftagq.push_back(ft);
  endtask

  // ---------------- behavioural instruction model ----------------
  task automatic build_trace();
    bit [15:0] ins, a, b, t, p;
    bit [3:0]  op;
    int        d, bs;
    string     atag = "R1", ftag = "R1";
    for (int i = 0; i < 8; i++) mr[i] = 16'h0;
    mpc = 16'h3000; mflg = 3'b010;
    for (int steps = 0; steps < 400 && int'(mpc) != end_pc; steps++) begin
      ins = mm[int'(mpc)];
      push(KIND_RD, mpc, 16'h0, mflg, atag, ftag);
      mpc = mpc + 1;
      op = ins[15:12]; d = int'(ins[11:9]); bs = int'(ins[8:6]);
      ftag = "R5";
      case (op)
        4'd0: if ((ins[11:9] & mflg) != 0) mpc = mpc + sx(ins, 9);
        4'd1, 4'd5: begin
          b = ins[5] ? sx(ins, 5) : mr[ins[2:0]];
          a = (op == 4'd1) ? mr[bs] + b : mr[bs] & b;
          mr[d] = a; ftag = "R4";
        end
        4'd9: begin mr[d] = ~mr[bs]; ftag = "R4"; end
        4'd14: begin mr[d] = mpc + sx(ins, 9); ftag = "R4"; end
        4'd2, 4'd6, 4'd10: begin
          a = (op == 4'd6) ? mr[bs] + sx(ins, 6) : mpc + sx(ins, 9);
          if (op == 4'd10) begin push(KIND_RD, a, 0, 0, tag_of(op), ""); a = mm[int'(a)]; end
          push(KIND_RD, a, 0, 0, tag_of(op), "");
          mr[d] = mm[int'(a)]; ftag = "R4";
        end
        4'd3, 4'd7, 4'd11: begin
          a = (op == 4'd7) ? mr[bs] + sx(ins, 6) : mpc + sx(ins, 9);
          if (op == 4'd11) begin push(KIND_RD, a, 0, 0, tag_of(op), ""); a = mm[int'(a)]; end
          push(KIND_WR, a, mr[d], 0, tag_of(op), "");
          mm[int'(a)] = mr[d];
        end
        4'd4: begin
          t = ins[11] ? mpc + sx(ins, 11) : mr[bs];
          mr[7] = mpc; mpc = t;
        end
        4'd12: mpc = mr[bs];
        default: begin
          push(KIND_EXC, mpc, ins, 0, "R11", "");
          mpc = mpc + 1;   // bench resumes one word past the raising instruction
        end
      endcase
      if (op != 4'd1 && op != 4'd5 && op != 4'd9 && op != 4'd14 &&
          op != 4'd2 && op != 4'd6 && op != 4'd10) p = 0;
      else begin
        a = mr[d];
        mflg = (a == 0) ? 3'b010 : (a[15] ? 3'b100 : 3'b001);
      end
      atag = tag_of(op);
    end
  endtask

  task automatic build_program();
    int loop, l2;
    ptr = 'h3000;
    emit(e_rel9(3, 2, ptr, D + 9));          // store zero register (R1)
    emit(e_alu_i(1, 1, 1, 5));
    loop = ptr;
    emit(e_alu_i(1, 1, 1, -1));
    emit(e_rel9(0, 1, ptr, loop));           // branch on positive
    emit(e_alu_i(1, 2, 1, -3));              // R2 = FFFD
    emit(e_alu_i(5, 3, 2, 7));               // 5
    emit(e_alu_i(5, 4, 3, 2));               // 0
    emit(e_alu_r(9, 5, 4, 0) | 16'h003f);    // not -> FFFF
    emit(e_rel9(0, 2, ptr, ptr + 2));        // zero: not taken
    emit(e_rel9(0, 4, ptr, ptr + 2));        // negative: taken
    emit(e_alu_i(1, 0, 0, 1));               // skipped
    emit(e_alu_r(1, 6, 2, 3));               // 2
    emit(e_alu_r(5, 6, 6, 5));               // 2
    emit(e_rel9(3, 6, ptr, D + 10));
    emit(e_rel9(2, 0, ptr, D + 0));
    emit(e_rel9(10, 1, ptr, D + 1));
    emit(e_rel9(14, 2, ptr, D + 2));
    emit(e_base(6, 3, 2, -2));
    emit(e_base(7, 3, 2, 5));
    emit(e_rel9(11, 0, ptr, D + 3));
    emit(e_rel9(2, 4, ptr, D + 7));
    emit(e_base(6, 5, 2, 14));
    emit(e_alu_i(1, 6, 6, 0));
    emit({4'd4, 1'b1, 11'(S - (ptr + 1))});  // long call
    emit(e_rel9(14, 1, ptr, S));
    emit({4'd4, 1'b0, 2'b00, 3'd1, 6'd0});   // call through register
    l2 = ptr + 3;
    emit(e_rel9(14, 3, ptr, l2));
    emit({4'd12, 3'd0, 3'd3, 6'd0});
    emit(16'h1021);                           // skipped
    emit(16'h8000); emit(16'h1021);
    emit(16'hD000); emit(16'h1021);
    emit(16'hF025); emit(16'h1021);
    emit(e_rel9(3, 7, ptr, D + 11));
    end_pc = ptr;
    emit(16'h0FFF);
    ptr = S;
    emit(e_rel9(3, 7, ptr, D + 12));
    emit(e_alu_i(1, 0, 0, 1));
    emit({4'd12, 3'd0, 3'd7, 6'd0});
    put(D + 0, 16'h8001);
    put(D + 1, 16'h3082);
    put(D + 2, 16'h0000);
    put(D + 3, 16'h3090);
  endtask

  initial begin
    int cyc = 0, pend = 0, ackc = 0;
    bit exc_seen = 0;
    bit [15:0] pdata = 0;
    ev_t e;
    string t, ft;
    build_program();
    build_trace();
    repeat (3) @(negedge clk);
    chk(cond_flags == 3'b010, "R1", "reset flags", int'(cond_flags), 2);
    chk(exc_req == 1'b0, "R1", "reset exc_req", int'(exc_req), 0);
    rst_n = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
        nvec++; nbad++;
        $display("FAIL R2 watchdog: actual %0d expected %0d", cyc, 20000);
        break;
      end
      exc_ack = 1'b0;
      if (ackc > 0) begin
        ackc--;
        if (ackc == 0) begin exc_ack = 1'b1; exc_target = exc_pc + 16'd1; end
      end
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = pdata; end
      end
      chk(!(exc_req && mem_req_valid), "R11", "request during hand-off", int'(mem_req_valid), 0);
      mem_req_ready = 1'b0;
      if (mem_req_valid && (cyc % 5) != 3) begin
        mem_req_ready = 1'b1;
        if (evq.size() == 0) break;
        e = evq.pop_front(); t = tagq.pop_front(); ft = ftagq.pop_front();
        chk(int'(e.kind) == (mem_req_write ? KIND_WR : KIND_RD), t, "request kind",
            int'(mem_req_write), int'(e.kind));
        chk(mem_req_addr == e.addr, t, "request address", int'(mem_req_addr), int'(e.addr));
        if (mem_req_write) begin
          chk(mem_req_wdata == e.data, t, "write data", int'(mem_req_wdata), int'(e.data));
          bmem[int'(mem_req_addr)] = mem_req_wdata;
        end else begin
          if (ft != "") chk(cond_flags == e.flg, ft, "flags at fetch", int'(cond_flags), int'(e.flg));
          pdata = bmem[int'(mem_req_addr)];
          pend = 1 + (cyc % 2);
        end
      end
      if (exc_req && !exc_seen) begin
        exc_seen = 1'b1;
        if (evq.size() == 0) break;
        e = evq.pop_front(); t = tagq.pop_front(); void'(ftagq.pop_front());
        chk(int'(e.kind) == KIND_EXC, "R11", "hand-off expected", int'(e.kind), KIND_EXC);
        chk(exc_instr == e.data, "R11", "hand-off instruction", int'(exc_instr), int'(e.data));
        chk(exc_pc == e.addr, "R11", "hand-off counter", int'(exc_pc), int'(e.addr));
        ackc = 2;
      end
      if (!exc_req) exc_seen = 1'b0;
      if (evq.size() == 0 && pend == 0 && !exc_req) break;
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule